// File: doc/BRIEF.md
# Management Data Clock Generator

This block derives the serial management clock for an Ethernet PHY management bus from the faster register clock. A 4-bit range-select field sits at bits 5:2 of the management address/control word. Software writes that word, and the block takes the field from it. Each select code names an even divide ratio. The standard codes have ratios from 16 to 124, and their order is not monotonic. A fourth select bit picks a set of small fast ratios from 4 to 18. These fast ratios lie outside the usual management-bus speed limit.

The generated clock has a 50% duty cycle. Alongside it, the block gives a one-cycle rising tick and a one-cycle falling tick, which a serial shift engine uses as its bit strobes. A new select value is taken up only at a falling edge of the generated clock, so no runt high phase can occur. The two reserved codes hold the clock low and set a sticky error flag.

Top module: `mgmt_clk_div`

## Requirements
- R1: After reset, `mdc`, `tick_rise`, `tick_fall` and `cfg_err` are low and the active select is 0000, giving a ratio of 42.
- R2: With select bit 3 (word bit 5) clear, codes 0000, 0001, 0010, 0011, 0100 and 0101 give `mdc` periods of 42, 62, 16, 26, 102 and 124 clock cycles.
- R3: Codes 1000 through 1111 give `mdc` periods of 4, 6, 8, 10, 12, 14, 16 and 18 clock cycles.
- R4: For a ratio R, `mdc` stays high for exactly R/2 cycles and low for exactly R/2 cycles.
- R5: `tick_rise` is high for exactly the one cycle in which `mdc` has just become 1, and `tick_fall` for the one cycle in which it has just become 0. The two are never high together.
- R6: The select field is the word shifted right by 2 and masked to 4 bits. Every other bit of the word, including the PHY register field at bits 10:6, has no effect on the period.
- R7: Writing code 0110 or 0111 sets `cfg_err` at the clock edge that accepts the write. `cfg_err` stays set until reset. While a reserved code is active, `mdc` stays low and no ticks occur.
- R8: A write accepted while `mdc` is running changes nothing until the next falling edge. The high phase in progress keeps the old ratio, and the low phase after the fall uses the new one.
- R9: With `en` low, `mdc` is low from the next clock edge and no ticks occur. After `en` rises, the first rising edge of `mdc` comes on the R/2-th clock edge.
- R10: While the clock is stopped, whether by `en` or by a reserved code, a valid write takes effect directly. `mdc` then first rises on the (R/2+1)-th edge after the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the address/control word |
| wr_data | input | 32 | Address/control word; select field at bits 5:2 |
| en | input | 1 | Run enable for the generated clock |
| mdc | output | 1 | Generated management clock |
| tick_rise | output | 1 | One-cycle pulse when `mdc` rises |
| tick_fall | output | 1 | One-cycle pulse when `mdc` falls |
| cfg_err | output | 1 | Sticky reserved-code flag |

## Verification
The `mdc` edges and both ticks are registered, so they are visible in the cycle after the clock edge that decides them. `cfg_err` becomes visible in the cycle right after the accepting write. The bench samples on the falling clock edge and counts those samples between tick events. It compares the counts with R/2 or R for the ratio that should be in force. A written select value is taken up only at a falling edge. For that reason the bench waits for a fall that comes after the write before it measures a new ratio, except in the R8 case, where it times the phase that is still running. After a stop or a write made while idle, it counts from the known edge: R/2 samples after enable, R/2+1 after a write.

// File: rtl/mgmt_clk_pkg.sv
package mgmt_clk_pkg;

  localparam int SEL_W    = 4;
  localparam int MAX_HALF = 62;
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] half_t;

  // codes 0110 and 0111 have no ratio
  function automatic logic sel_reserved(input sel_t code);
    return (code[3] == 1'b0) && (code[2:1] == 2'b11);
  endfunction

  // half of the divide ratio; fast set is 2 + low bits
  function automatic half_t half_of(input sel_t code);
    half_t h;
    if (code[3]) begin
      h = half_t'(2) + half_t'(code[2:0]);
    end else begin
      unique case (code[2:0])
        3'b000:  h = half_t'(21);
        3'b001:  h = half_t'(31);
        3'b010:  h = half_t'(8);
        3'b011:  h = half_t'(13);
        3'b100:  h = half_t'(51);
        3'b101:  h = half_t'(62);
        default: h = half_t'(21);
      endcase
    end
    return h;
  endfunction

endpackage

// File: rtl/mgmt_sel_capture.sv
module mgmt_sel_capture
  import mgmt_clk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SEL_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output sel_t              active_sel,
  output logic              err
);

  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((1 << SEL_W) - 1);

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] masked;
  sel_t              field;
  logic              unused_hi;

  sel_t pend_q, pend_d;
  sel_t act_q, act_d;
  logic err_q, err_d;

  // position first, then mask
  assign shifted   = wr_data >> SEL_LSB;
  assign masked    = shifted & FIELD_MASK;
  assign field     = masked[SEL_W-1:0];
  assign unused_hi = ^masked[DATA_W-1:SEL_W];

  always_comb begin
    pend_d = pend_q;
    if (wr_en) pend_d = field;
    act_d = act_q;
    if (load) act_d = pend_q;
    err_d = err_q | (wr_en & sel_reserved(field));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      err_q  <= err_d;
    end
  end

  assign active_sel = act_q;
  assign err        = err_q;

  // R7: error flag never clears outside reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R6: pending select moves only on a write
  a_r6_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_q));

endmodule

// File: rtl/mgmt_phase_gen.sv
module mgmt_phase_gen
  import mgmt_clk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  half_t half,
  output logic  mdc,
  output logic  tick_rise,
  output logic  tick_fall,
  output logic  fall_evt
);

  half_t cnt_q, cnt_d;
  logic  mdc_q, mdc_d;
  logic  rise_q, rise_d;
  logic  fall_q, fall_d;
  logic  term;

  assign term     = run && (cnt_q == half - half_t'(1));
  assign fall_evt = term && mdc_q;

  always_comb begin
    cnt_d  = cnt_q;
    mdc_d  = mdc_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d  = '0;
      mdc_d  = ~mdc_q;
      rise_d = ~mdc_q;
      fall_d = mdc_q;
    end else begin
      cnt_d = cnt_q + half_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mdc_q  <= mdc_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign mdc       = mdc_q;
  assign tick_rise = rise_q;
  assign tick_fall = fall_q;

  // R4: counter never passes the half period in use
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));

  // R5: ticks line up with mdc transitions
  a_r5_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> (mdc_q && !$past(mdc_q)));
  a_r5_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> (!mdc_q && $past(mdc_q)));
  a_r5_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_q, fall_q}));

endmodule

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div
  import mgmt_clk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SEL_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              en,
  output logic              mdc,
  output logic              tick_rise,
  output logic              tick_fall,
  output logic              cfg_err
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  sel_t       active_sel;
  half_t      half;
  logic       active_rsvd;
  logic       run;
  logic       fall_evt;
  logic       load;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign half        = half_of(active_sel);
  assign active_rsvd = sel_reserved(active_sel);
  assign run         = en && !active_rsvd;
  assign load        = fall_evt || !run;

  mgmt_sel_capture #(
    .DATA_W  (DATA_W),
    .SEL_LSB (SEL_LSB)
  ) u_sel (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .load       (load),
    .active_sel (active_sel),
    .err        (cfg_err)
  );

  mgmt_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .run       (run),
    .half      (half),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .fall_evt  (fall_evt)
  );

  // R8: the select in force only changes while mdc is low
  a_r8_switch_low: assert property (@(posedge clk) disable iff (!core_rst_n)
    (active_sel != $past(active_sel)) |-> !mdc);

  // R9: disabled means quiet
  a_r9_quiet_off: assert property (@(posedge clk) disable iff (!core_rst_n)
    !en |=> (!tick_rise && !tick_fall && !mdc));

  // R7: reserved select stops the clock
  a_r7_rsvd_idle: assert property (@(posedge clk) disable iff (!core_rst_n)
    active_rsvd |=> (!mdc && !tick_rise && !tick_fall));

endmodule

// File: tb/mgmt_clk_div_tb_top.sv
module mgmt_clk_div_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        en;
  logic        mdc, tick_rise, tick_fall, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mgmt_clk_div dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .en        (en),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .cfg_err   (cfg_err)
  );

  function automatic int ratio_of(input logic [3:0] c);
    case (c)
      4'h0: return 42;  4'h1: return 62;  4'h2: return 16;
      4'h3: return 26;  4'h4: return 102; 4'h5: return 124;
      4'h8: return 4;   4'h9: return 6;   4'hA: return 8;
      4'hB: return 10;  4'hC: return 12;  4'hD: return 14;
      4'hE: return 16;  4'hF: return 18;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [31:0] word_for(input logic [3:0] c);
    return ($urandom() & ~32'h3C) | (32'(c) << 2);
  endfunction

  // waits for a fall, then times low phase, high phase and full period
  task automatic measure(input int r, input string req);
    int n, hi;
    bit tick_ok;
    tick_ok = 1;
    do @(negedge clk); while (!tick_fall);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!tick_rise);
    chk(n == r/2, "R4 low phase", n, r/2);
    n = 0; hi = 0;
    do begin
      @(negedge clk); n++;
      if (tick_fall) hi = n;
      if (tick_rise && tick_fall) tick_ok = 0;
      if (tick_fall && mdc) tick_ok = 0;
    end while (!tick_rise);
    chk(n == r, req, n, r);
    chk(hi == r/2, "R4 high phase", hi, r/2);
    chk(tick_ok && mdc, "R5 tick alignment", int'(tick_ok), 1);
  endtask

  initial begin
    int n;
    bit quiet;
    logic [31:0] w;
    logic [3:0] c;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; en = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    chk(!mdc && !tick_rise && !tick_fall && !cfg_err, "R1 reset outputs",
        int'({mdc, tick_rise, tick_fall, cfg_err}), 0);
    rst_n = 1'b1;
    measure(42, "R1 default ratio");

    // every valid code, other word bits randomised
    for (int k = 0; k < 16; k++) begin
      c = 4'(k);
      if (ratio_of(c) == 0) continue;
      wr(word_for(c));
      measure(ratio_of(c), c[3] ? "R3 fast ratio" : "R2 standard ratio");
    end

    // R6: PHY register field all ones, field code 0100
    wr(32'hFFFF_FFC3 | (32'h4 << 2));
    measure(102, "R6 neighbour bits ignored");

    // random words, forced to a valid code
    for (int k = 0; k < 12; k++) begin
      w = $urandom();
      if (w[5] == 1'b0 && w[4:3] == 2'b11) w[5] = 1'b1;
      wr(w);
      measure(ratio_of(w[5:2]), "R2 R3 R6 random word");
    end

    // R8: write during a high phase
    wr(word_for(4'hF));
    measure(18, "R3 fast ratio");
    do @(negedge clk); while (!tick_rise);
    wr_en = 1'b1; wr_data = word_for(4'h8);
    n = 0;
    do begin
      @(negedge clk); n++; wr_en = 1'b0;
    end while (!tick_fall);
    chk(n == 9, "R8 high phase keeps old ratio", n, 9);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_rise);
    chk(n == 2, "R8 new ratio after fall", n, 2);

    // R9: enable control
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(!mdc, "R9 mdc low after disable", int'(mdc), 0);
    quiet = 1;
    repeat (20) begin
      @(negedge clk);
      if (mdc || tick_rise || tick_fall) quiet = 0;
    end
    chk(quiet, "R9 no ticks while disabled", int'(quiet), 1);
    wr(word_for(4'h3));
    @(negedge clk); en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_rise);
    chk(n == 13, "R9 first rise after enable", n, 13);

    // R7 and R10: reserved code, then recovery
    wr(word_for(4'h6));
    chk(cfg_err, "R7 error on reserved write", int'(cfg_err), 1);
    repeat (60) @(negedge clk);
    quiet = 1;
    repeat (200) begin
      @(negedge clk);
      if (mdc || tick_rise || tick_fall) quiet = 0;
    end
    chk(quiet, "R7 clock held while reserved", int'(quiet), 1);
    wr(word_for(4'h2));
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_rise);
    chk(n == 9, "R10 restart from idle", n, 9);
    chk(cfg_err, "R7 error stays set", int'(cfg_err), 1);
    measure(16, "R2 standard ratio");
    wr(word_for(4'h7));
    chk(cfg_err, "R7 second reserved code", int'(cfg_err), 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk(!cfg_err && !mdc, "R1 reset clears error", int'({cfg_err, mdc}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
    end
  end

endmodule